// File: doc/BRIEF.md
# LIN Slave Break Detector and Status Flags

This unit sits beside the receiver and transmitter of a UART that can run a LIN slave. It watches the receive line and measures how long the line stays low, counting bit-time ticks. It raises a break flag when that low period reaches a limit set by the current LIN state. The limit is short in sleep, where any long low is a wake-up. It is longest while waiting for a frame header, and slightly shorter while a frame is in progress.

It also compares the bus against the bit being transmitted and flags a physical-layer fault on a mismatch. It collects strobes from the receiver, the baud counter and the transmit path into an eight-bit status word. Each flag in that word holds until software reads the status word or the receive data. Which of the two reads clears a flag depends on the flag.

Top module: `lin_status_unit`

## Requirements
- R1: `status_o` bit positions, MSB to LSB: 7 data ready, 6 bus fault, 5 overrun, 4 framing error, 3 break, 2 transmit holding empty, 1 transmitter idle, 0 autobaud done. After reset `status_o` is 8'b0000_0110.
- R2: With `lin_state_i` = 2'd0 (sleep), the rising clock edge that carries the 4th `bit_tick_i` of one unbroken low period on `rx_i` sets bit 3. A 3-tick low period does not set it.
- R3: With `lin_state_i` = 2'd1 (wait for break), bit 3 sets on the 11th tick of a low period. A 10-tick low period does not set it.
- R4: With `lin_state_i` = 2'd2 (active), bit 3 sets on the 10th tick of a low period. A 9-tick low period does not set it. With state 2'd3, no low period sets it.
- R5: The low-period count returns to zero in any cycle with `rx_i` high. Within one low period, bit 3 is raised at most once, when the threshold is first reached, even if the line stays low for more ticks.
- R6: Bit 6 sets on a cycle where `mid_bit_i` and `tx_active_i` are both high and `rx_i` differs from `tx_bit_i`. Without both strobes, a mismatch has no effect.
- R7: Bits 6 and 3 clear on `stat_rd_i` or `rdr_rd_i`.
- R8: Bits 7, 5 and 4 clear only on `rdr_rd_i`; `stat_rd_i` leaves them set. For bits 7 to 3 and bit 0, a set strobe in the same cycle as a clearing read wins.
- R9: `rx_done_i` sets bit 7. If bit 7 is already set and `rdr_rd_i` is low in that cycle, bit 5 sets too. `frame_err_i` sets bit 4.
- R10: `autobaud_done_i` sets bit 0. `baud_ovf_i` sets both bit 5 and bit 0. Bit 0 clears on `stat_rd_i`.
- R11: `tdr_wr_i` clears bit 2. `tx_load_i` sets bit 2 and clears bit 1. `tx_done_i` sets bit 1. For bits 2 and 1, the clear wins over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Synchronised, oversampled receive line |
| tx_bit_i | input | 1 | Bit currently driven by the transmitter |
| tx_active_i | input | 1 | Transmitter is driving a bit |
| mid_bit_i | input | 1 | Mid-bit sample strobe |
| bit_tick_i | input | 1 | One pulse per bit time |
| lin_state_i | input | 2 | 0 sleep, 1 wait for break, 2 active, 3 no break detection |
| rx_done_i | input | 1 | Character received into the data register |
| frame_err_i | input | 1 | Stop bit missing on received character |
| autobaud_done_i | input | 1 | Autobaud sequence finished |
| baud_ovf_i | input | 1 | Baud counter overflowed during autobaud |
| tdr_wr_i | input | 1 | Transmit data register written |
| tx_load_i | input | 1 | Shifter took the transmit data register |
| tx_done_i | input | 1 | Last bit of the character shifted out |
| stat_rd_i | input | 1 | Status word read |
| rdr_rd_i | input | 1 | Receive data register read |
| status_o | output | 8 | Status word |

## Verification
Two functions can land in the same cycle: a new event that sets a flag, and a software read that clears it. Examples are a character arriving while the data register is read, or a break threshold being reached during a status read. Directed steps put `rx_done_i` and `rdr_rd_i` in one cycle. They expect data ready to stay set and no overrun. The random phase fires every strobe independently, so set/clear collisions occur on every flag. A bench model scores each cycle with set-wins or clear-wins resolved per bit.

// File: rtl/lin_stat_pkg.sv
package lin_stat_pkg;
  typedef enum logic [1:0] {
    LS_SLEEP    = 2'd0,
    LS_WAIT_BRK = 2'd1,
    LS_ACTIVE   = 2'd2,
    LS_OFF      = 2'd3
  } lin_state_e;

  localparam int unsigned NUM_FLAGS = 8;
  localparam int unsigned F_RDA  = 7;
  localparam int unsigned F_PHY  = 6;
  localparam int unsigned F_OVR  = 5;
  localparam int unsigned F_FRM  = 4;
  localparam int unsigned F_BRK  = 3;
  localparam int unsigned F_THE  = 2;
  localparam int unsigned F_TIDL = 1;
  localparam int unsigned F_ABD  = 0;

  localparam logic [NUM_FLAGS-1:0] FLAG_RST      = 8'b0000_0110;
  // 1: set beats clear on collision; 0: clear beats set
  localparam logic [NUM_FLAGS-1:0] FLAG_SET_WINS = 8'b1111_1001;
endpackage

// File: rtl/lin_break_det.sv
module lin_break_det #(
  parameter int unsigned SLEEP_BITS  = 4,
  parameter int unsigned WAIT_BITS   = 11,
  parameter int unsigned ACTIVE_BITS = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       bit_tick_i,
  input  logic [1:0] lin_state_i,
  output logic       brk_o
);
  import lin_stat_pkg::*;

  localparam int unsigned MAX_A   = (SLEEP_BITS > WAIT_BITS) ? SLEEP_BITS : WAIT_BITS;
  localparam int unsigned MAX_THR = (MAX_A > ACTIVE_BITS) ? MAX_A : ACTIVE_BITS;
  localparam int unsigned CNT_W   = $clog2(MAX_THR + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_THR);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, thr;
  logic             adv;

  always_comb begin
    unique case (lin_state_e'(lin_state_i))
      LS_SLEEP:    thr = CNT_W'(SLEEP_BITS);
      LS_WAIT_BRK: thr = CNT_W'(WAIT_BITS);
      LS_ACTIVE:   thr = CNT_W'(ACTIVE_BITS);
      default:     thr = '0;
    endcase
  end

  // saturate so a long low can never match the threshold twice
  assign adv     = !rx_i && bit_tick_i && (cnt_q != CNT_MAX);
  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (rx_i) cnt_q <= '0;
    else if (adv)  cnt_q <= cnt_nxt;
  end

  assign brk_o = adv && (thr != '0) && (cnt_nxt == thr);
endmodule

// File: rtl/lin_readback_chk.sv
module lin_readback_chk (
  input  logic rx_i,
  input  logic tx_bit_i,
  input  logic tx_active_i,
  input  logic mid_bit_i,
  output logic fault_o
);
  assign fault_o = mid_bit_i && tx_active_i && (rx_i != tx_bit_i);
endmodule

// File: rtl/lin_stat_flag.sv
module lin_stat_flag #(
  parameter logic RST_VAL  = 1'b0,
  parameter logic SET_WINS = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  generate
    if (SET_WINS) begin : g_set_wins
      assign q_d = set_i | (q_o & ~clr_i);
    end else begin : g_clr_wins
      assign q_d = ~clr_i & (set_i | q_o);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/lin_status_unit.sv
module lin_status_unit #(
  parameter int unsigned SLEEP_BITS  = 4,
  parameter int unsigned WAIT_BITS   = 11,
  parameter int unsigned ACTIVE_BITS = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       tx_bit_i,
  input  logic       tx_active_i,
  input  logic       mid_bit_i,
  input  logic       bit_tick_i,
  input  logic [1:0] lin_state_i,
  input  logic       rx_done_i,
  input  logic       frame_err_i,
  input  logic       autobaud_done_i,
  input  logic       baud_ovf_i,
  input  logic       tdr_wr_i,
  input  logic       tx_load_i,
  input  logic       tx_done_i,
  input  logic       stat_rd_i,
  input  logic       rdr_rd_i,
  output logic [7:0] status_o
);
  import lin_stat_pkg::*;

  logic                 brk_evt, phy_evt;
  logic [NUM_FLAGS-1:0] set_v, clr_v, flag_q;

  lin_break_det #(
    .SLEEP_BITS (SLEEP_BITS),
    .WAIT_BITS  (WAIT_BITS),
    .ACTIVE_BITS(ACTIVE_BITS)
  ) i_brk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_i       (rx_i),
    .bit_tick_i (bit_tick_i),
    .lin_state_i(lin_state_i),
    .brk_o      (brk_evt)
  );

  lin_readback_chk i_rbk (
    .rx_i       (rx_i),
    .tx_bit_i   (tx_bit_i),
    .tx_active_i(tx_active_i),
    .mid_bit_i  (mid_bit_i),
    .fault_o    (phy_evt)
  );

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[F_RDA]  = rx_done_i;
    clr_v[F_RDA]  = rdr_rd_i;
    set_v[F_PHY]  = phy_evt;
    clr_v[F_PHY]  = stat_rd_i | rdr_rd_i;
    set_v[F_OVR]  = (rx_done_i & flag_q[F_RDA] & ~rdr_rd_i) | baud_ovf_i;
    clr_v[F_OVR]  = rdr_rd_i;
    set_v[F_FRM]  = frame_err_i;
    clr_v[F_FRM]  = rdr_rd_i;
    set_v[F_BRK]  = brk_evt;
    clr_v[F_BRK]  = stat_rd_i | rdr_rd_i;
    set_v[F_THE]  = tx_load_i;
    clr_v[F_THE]  = tdr_wr_i;
    set_v[F_TIDL] = tx_done_i;
    clr_v[F_TIDL] = tx_load_i;
    set_v[F_ABD]  = autobaud_done_i | baud_ovf_i;
    clr_v[F_ABD]  = stat_rd_i;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    lin_stat_flag #(
      .RST_VAL (FLAG_RST[g]),
      .SET_WINS(FLAG_SET_WINS[g])
    ) i_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .q_o   (flag_q[g])
    );
  end

  assign status_o = flag_q;
endmodule

// File: rtl/lin_status_chk.sv
module lin_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_i,
  input logic       tx_bit_i,
  input logic       tx_active_i,
  input logic       mid_bit_i,
  input logic       bit_tick_i,
  input logic       rx_done_i,
  input logic       baud_ovf_i,
  input logic       tdr_wr_i,
  input logic       stat_rd_i,
  input logic       rdr_rd_i,
  input logic [7:0] status_o
);
  // R6
  assert_phy_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_bit_i && tx_active_i && (rx_i != tx_bit_i) |=> status_o[6]);

  // R8
  assert_rda_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdr_rd_i && !rx_done_i |=> !status_o[7]);

  assert_rda_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && !rdr_rd_i && status_o[7] |=> status_o[7]);

  // R10
  assert_ovf_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_ovf_i |=> status_o[5] && status_o[0]);

  // R11
  assert_tdr_wr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tdr_wr_i |=> !status_o[2]);

  // R5
  assert_brk_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[3]) |-> $past(bit_tick_i) && !$past(rx_i));
endmodule

bind lin_status_unit lin_status_chk i_lin_status_chk (.*);

// File: tb/test_lin_status_unit.sv
module test_lin_status_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       rx_i, tx_bit_i, tx_active_i, mid_bit_i, bit_tick_i;
  logic [1:0] lin_state_i;
  logic       rx_done_i, frame_err_i, autobaud_done_i, baud_ovf_i;
  logic       tdr_wr_i, tx_load_i, tx_done_i, stat_rd_i, rdr_rd_i;
  logic [7:0] status_o;

  int   n_chk = 0, n_err = 0;
  int   m_cnt = 0;
  logic [7:0] exp_s = 8'b0000_0110;
  bit   done = 0;

  always #10 clk_i = ~clk_i;

  lin_status_unit i_lin_status_unit (.*);

  function automatic string bit_req(int b);
    case (b)
      7, 4:    return "R8";
      6:       return "R6";
      5:       return "R9";
      3:       return "R2";
      2, 1:    return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, logic act, logic expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, expv, $time);
    end
  endtask

  task automatic model_next();
    int thr;
    logic brk;
    logic [7:0] s, c, n;
    thr = (lin_state_i == 2'd0) ? 4 : (lin_state_i == 2'd1) ? 11 :
          (lin_state_i == 2'd2) ? 10 : 0;
    brk = 1'b0;
    if (rx_i) m_cnt = 0;
    else if (bit_tick_i && m_cnt < 11) begin
      m_cnt++;
      brk = (m_cnt == thr);
    end
    s = '0; c = '0;
    s[7] = rx_done_i;                                      c[7] = rdr_rd_i;
    s[6] = mid_bit_i && tx_active_i && (rx_i != tx_bit_i); c[6] = stat_rd_i | rdr_rd_i;
    s[5] = (rx_done_i && exp_s[7] && !rdr_rd_i) || baud_ovf_i; c[5] = rdr_rd_i;
    s[4] = frame_err_i;                                    c[4] = rdr_rd_i;
    s[3] = brk;                                            c[3] = stat_rd_i | rdr_rd_i;
    s[2] = tx_load_i;                                      c[2] = tdr_wr_i;
    s[1] = tx_done_i;                                      c[1] = tx_load_i;
    s[0] = autobaud_done_i | baud_ovf_i;                   c[0] = stat_rd_i;
    for (int i = 0; i < 8; i++) begin
      if (i == 1 || i == 2) n[i] = c[i] ? 1'b0 : (s[i] ? 1'b1 : exp_s[i]);
      else                  n[i] = s[i] ? 1'b1 : (c[i] ? 1'b0 : exp_s[i]);
    end
    exp_s = n;
  endtask

  task automatic clr_strobes();
    mid_bit_i = 0; bit_tick_i = 0; rx_done_i = 0; frame_err_i = 0;
    autobaud_done_i = 0; baud_ovf_i = 0; tdr_wr_i = 0; tx_load_i = 0;
    tx_done_i = 0; stat_rd_i = 0; rdr_rd_i = 0;
  endtask

  // one clock: model, edge, compare every bit at the following negedge
  task automatic cyc();
    model_next();
    @(posedge clk_i);
    @(negedge clk_i);
    for (int b = 0; b < 8; b++) chk(bit_req(b), status_o[b], exp_s[b]);
    clr_strobes();
  endtask

  task automatic low_period(logic [1:0] st, int ticks);
    lin_state_i = st;
    rx_i = 1; stat_rd_i = 1; cyc();
    rx_i = 0;
    for (int k = 0; k < ticks; k++) begin
      bit_tick_i = 1; cyc();
      cyc();
    end
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1a2b));
    rst_ni = 0; rx_i = 1; tx_bit_i = 1; tx_active_i = 0; lin_state_i = 2'd1;
    clr_strobes();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1", status_o == 8'b0000_0110, 1'b1);

    // break thresholds per state
    low_period(2'd0, 3);  chk("R2", status_o[3], 1'b0);
    low_period(2'd0, 4);  chk("R2", status_o[3], 1'b1);
    low_period(2'd1, 10); chk("R3", status_o[3], 1'b0);
    low_period(2'd1, 11); chk("R3", status_o[3], 1'b1);
    low_period(2'd2, 9);  chk("R4", status_o[3], 1'b0);
    low_period(2'd2, 10); chk("R4", status_o[3], 1'b1);
    low_period(2'd3, 11); chk("R4", status_o[3], 1'b0);

    // once per low period; count restarts after high
    low_period(2'd2, 10);
    stat_rd_i = 1; cyc(); chk("R7", status_o[3], 1'b0);
    for (int k = 0; k < 5; k++) begin bit_tick_i = 1; cyc(); end
    chk("R5", status_o[3], 1'b0);
    low_period(2'd2, 10); chk("R5", status_o[3], 1'b1);
    rdr_rd_i = 1; cyc(); chk("R7", status_o[3], 1'b0);
    rx_i = 1; cyc();

    // readback
    tx_active_i = 1; tx_bit_i = 1; mid_bit_i = 1; cyc();
    chk("R6", status_o[6], 1'b0);
    tx_bit_i = 0; cyc(); chk("R6", status_o[6], 1'b0);
    tx_active_i = 0; mid_bit_i = 1; cyc(); chk("R6", status_o[6], 1'b0);
    tx_active_i = 1; mid_bit_i = 1; cyc(); chk("R6", status_o[6], 1'b1);
    rdr_rd_i = 1; cyc(); chk("R7", status_o[6], 1'b0);
    tx_active_i = 0; tx_bit_i = 1;

    // receive flags and overrun
    rx_done_i = 1; frame_err_i = 1; cyc(); chk("R9", status_o[7], 1'b1);
    stat_rd_i = 1; cyc(); chk("R8", status_o[7:4] == 4'b1001, 1'b1);
    rx_done_i = 1; cyc(); chk("R9", status_o[5], 1'b1);
    rdr_rd_i = 1; cyc(); chk("R8", status_o[7:4] == 4'b0000, 1'b1);
    rx_done_i = 1; cyc();
    rx_done_i = 1; rdr_rd_i = 1; cyc();
    chk("R8", status_o[7], 1'b1); chk("R9", status_o[5], 1'b0);
    rdr_rd_i = 1; cyc();

    // autobaud
    baud_ovf_i = 1; cyc(); chk("R10", status_o[5] & status_o[0], 1'b1);
    stat_rd_i = 1; cyc(); chk("R10", status_o[0], 1'b0); chk("R8", status_o[5], 1'b1);
    autobaud_done_i = 1; cyc(); chk("R10", status_o[0], 1'b1);
    rdr_rd_i = 1; stat_rd_i = 1; cyc();

    // transmit path
    tdr_wr_i = 1; cyc(); chk("R11", status_o[2:1] == 2'b01, 1'b1);
    tx_load_i = 1; cyc(); chk("R11", status_o[2:1] == 2'b10, 1'b1);
    tdr_wr_i = 1; cyc();
    tx_done_i = 1; tx_load_i = 1; cyc(); chk("R11", status_o[2:1] == 2'b10, 1'b1);
    tx_done_i = 1; cyc(); chk("R11", status_o[1], 1'b1);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(39) == 0) rx_i = ~rx_i;
      if ($urandom_range(299) == 0) lin_state_i = 2'($urandom_range(3));
      if ($urandom_range(29) == 0) tx_active_i = ~tx_active_i;
      bit_tick_i      = ($urandom_range(3) == 0);
      mid_bit_i       = ($urandom_range(7) == 0);
      if (mid_bit_i) tx_bit_i = 1'($urandom_range(1));
      rx_done_i       = ($urandom_range(19) == 0);
      frame_err_i     = ($urandom_range(39) == 0);
      autobaud_done_i = ($urandom_range(49) == 0);
      baud_ovf_i      = ($urandom_range(79) == 0);
      tdr_wr_i        = ($urandom_range(19) == 0);
      tx_load_i       = ($urandom_range(19) == 0);
      tx_done_i       = ($urandom_range(19) == 0);
      stat_rd_i       = ($urandom_range(24) == 0);
      rdr_rd_i        = ($urandom_range(24) == 0);
      cyc();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule